// File: doc/BRIEF.md
# Client Hot-Reset Flush Sequencer

This block sits between a set of memory-request clients and the arbiter that serves them. Each client has a one-entry holding slot in front of arbitration. The block also keeps a count of the requests that the arbiter has taken and that have not yet completed. A client can be fenced off in two ways. Software can set its bit in the block register. A hot-reset request line can also start an ordered handshake for it.

The handshake has three steps. First the client is blocked. Next the block waits until the client's outstanding count drains to zero. Only then is hot reset applied, and hot reset discards whatever still waits in the holding slot. Release runs in reverse order: hot reset is removed first, and the block bit is removed one cycle later. If the drain does not finish within a parameterised number of cycles, hot reset is never applied and a sticky per-client timeout flag is raised. Software clears that flag by writing a one to it.

Top module: `hrf_top`

## Requirements
- R1: While a client is blocked (its software bit or its sequencer holds it), its req_ready_o and arb_valid_o are 0. Clearing the block lets its traffic flow again.
- R2: Each client has a one-entry holding slot. req_ready_o is 1 only when the client is unblocked and the slot is empty. A held request drives arb_valid_o with its data unchanged until arb_ready_i takes it.
- R3: The outstanding count rises on each arbiter handshake and falls on rsp_done_i. rsp_done_i at a count of zero is ignored. The count saturates at MAX_OUT (default 15) because arb_valid_o is withheld at that value.
- R4: A rising hr_req_i blocks the client at the next edge. hr_active_o rises only at the edge after the count has been seen at zero while blocked.
- R5: Hot reset empties the holding slot and leaves the outstanding count unchanged.
- R6: When hr_req_i falls during hot reset, hr_active_o drops at the next edge while the block stays. The block clears one edge later.
- R7: If the count is still nonzero DRAIN_TO (default 64) edges after the block takes effect, the client's timeout flag is set and stays set. hot reset is not applied for that attempt, and the block holds until hr_req_i falls, then clears at the next edge.
- R8: Register address 0 reads the effective block bits (software OR sequencer), and writing it loads the software bits. Address 1 reads the idle bits (count is zero). Address 2 reads the timeout flags. Address 3 reads hr_active_o.
- R9: Writing address 2 clears each timeout flag whose write-data bit is 1. A timeout in the same cycle wins over the clear.
- R10: After reset, every client is unblocked, idle, has no timeout and no hot reset, and its holding slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | N_CLIENTS | Register write data |
| reg_rdata_o | output | N_CLIENTS | Register read data (combinational) |
| req_valid_i | input | N_CLIENTS | Client request valid |
| req_data_i | input | N_CLIENTS*DATA_W | Client request payloads |
| req_ready_o | output | N_CLIENTS | Client request ready |
| arb_valid_o | output | N_CLIENTS | Request valid toward the arbiter |
| arb_data_o | output | N_CLIENTS*DATA_W | Payloads toward the arbiter |
| arb_ready_i | input | N_CLIENTS | Arbiter accept |
| rsp_done_i | input | N_CLIENTS | Completion pulse per client |
| hr_req_i | input | N_CLIENTS | Hot-reset request level per client |
| hr_active_o | output | N_CLIENTS | Hot reset applied per client |

## Verification
Two events can land in the same cycle. The first is a drain completion, when a response arrives that brings the count to zero. The second is the sequencer's check of idle. The bench pulses rsp_done_i while the client is blocked and not idle. It then checks that hot reset waits one more edge, so that it follows the registered zero count and not the pulse itself. The arbiter handshake and a response can also arrive together at the saturation point. Random traffic with random software blocking is compared every cycle against a bench model of the counts and holding slots. Directed runs cover saturation, ignored responses at zero, timeout with write-one-clear, and the flush.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_DRAIN = 3'd1,
    SQ_HRST  = 3'd2,
    SQ_UNRST = 3'd3,
    SQ_FAIL  = 3'd4
  } sq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IDLE = 2'd1;
  localparam logic [1:0] ADDR_TOUT = 2'd2;
  localparam logic [1:0] ADDR_HRST = 2'd3;

  // next outstanding count: a completion at zero is dropped
  function automatic logic [31:0] cnt_step(logic [31:0] cur, logic inc, logic dec);
    logic [31:0] nxt;
    nxt = cur + {31'd0, inc};
    if (dec && cur != 32'd0) nxt = nxt - 32'd1;
    return nxt;
  endfunction

  function automatic logic [31:0] rd_sel(logic [1:0] a, logic [31:0] ctl,
                                         logic [31:0] idl, logic [31:0] tou,
                                         logic [31:0] hrs);
    case (a)
      ADDR_CTRL: return ctl;
      ADDR_IDLE: return idl;
      ADDR_TOUT: return tou;
      default:   return hrs;
    endcase
  endfunction

endpackage

// File: rtl/hrf_chan.sv
module hrf_chan
  import hrf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_OUT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block_i,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              req_ready_o,
  output logic              arb_valid_o,
  output logic [DATA_W-1:0] arb_data_o,
  input  logic              arb_ready_i,
  input  logic              rsp_done_i,
  output logic              idle_o
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic              held_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, acc, arb_fire;

  assign full        = (cnt_q == CNT_W'(MAX_OUT));
  assign req_ready_o = !block_i && !held_q;
  assign acc         = req_valid_i && req_ready_o;
  assign arb_valid_o = held_q && !block_i && !full;
  assign arb_fire    = arb_valid_o && arb_ready_i;
  assign arb_data_o  = data_q;
  assign idle_o      = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (flush_i)       held_q <= 1'b0;
      else if (acc) begin
        held_q <= 1'b1;
        data_q <= req_data_i;
      end else if (arb_fire) held_q <= 1'b0;
      cnt_q <= CNT_W'(cnt_step(32'(cnt_q), arb_fire, rsp_done_i));
    end
  end

  // R2: a held entry waits with stable data until taken or flushed
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !arb_fire && !flush_i |=> held_q && $stable(data_q));
  // R3: the count never wraps at either end
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'(MAX_OUT) |=> cnt_q >= CNT_W'(MAX_OUT - 1));
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 |=> cnt_q <= CNT_W'(1));
  // R5: flush empties the slot and leaves the count alone
  a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !held_q && $stable(cnt_q));
endmodule

// File: rtl/hrf_seq.sv
module hrf_seq
  import hrf_pkg::*;
#(
  parameter int DRAIN_TO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hr_req_i,
  input  logic idle_i,
  output logic blk_o,
  output logic hrst_o,
  output logic tout_o
);
  localparam int TMR_W = $clog2(DRAIN_TO + 1);

  sq_state_e         state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              tmr_end;

  assign tmr_end = (tmr_q == TMR_W'(DRAIN_TO - 1));
  assign blk_o   = (state_q != SQ_RUN);
  assign hrst_o  = (state_q == SQ_HRST);
  assign tout_o  = (state_q == SQ_DRAIN) && hr_req_i && !idle_i && tmr_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RUN;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        SQ_RUN: if (hr_req_i) begin
          state_q <= SQ_DRAIN;
          tmr_q   <= '0;
        end
        SQ_DRAIN: begin
          if (!hr_req_i)    state_q <= SQ_RUN;
          else if (idle_i)  state_q <= SQ_HRST;
          else if (tmr_end) state_q <= SQ_FAIL;
          else              tmr_q   <= tmr_q + 1'b1;
        end
        SQ_HRST:  if (!hr_req_i) state_q <= SQ_UNRST;
        SQ_UNRST: state_q <= SQ_RUN;
        SQ_FAIL:  if (!hr_req_i) state_q <= SQ_RUN;
        default:  state_q <= SQ_RUN;
      endcase
    end
  end

  // R4: hot reset only follows a drain that saw idle
  a_r4_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrst_o) |-> $past(idle_i) && $past(blk_o));
  // R6: leaving hot reset keeps the block one more cycle
  a_r6_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hrst_o) |-> blk_o);
  // R7: a failed drain never turns into hot reset
  a_r7_fail_no_hrst: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_FAIL |=> !hrst_o);
  a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SQ_DRAIN |-> tmr_q < TMR_W'(DRAIN_TO));
endmodule

// File: rtl/hrf_top.sv
module hrf_top
  import hrf_pkg::*;
#(
  parameter int N_CLIENTS = 8,
  parameter int DATA_W    = 16,
  parameter int MAX_OUT   = 15,
  parameter int DRAIN_TO  = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we_i,
  input  logic [1:0]                    reg_addr_i,
  input  logic [N_CLIENTS-1:0]          reg_wdata_i,
  output logic [N_CLIENTS-1:0]          reg_rdata_o,
  input  logic [N_CLIENTS-1:0]          req_valid_i,
  input  logic [N_CLIENTS*DATA_W-1:0]   req_data_i,
  output logic [N_CLIENTS-1:0]          req_ready_o,
  output logic [N_CLIENTS-1:0]          arb_valid_o,
  output logic [N_CLIENTS*DATA_W-1:0]   arb_data_o,
  input  logic [N_CLIENTS-1:0]          arb_ready_i,
  input  logic [N_CLIENTS-1:0]          rsp_done_i,
  input  logic [N_CLIENTS-1:0]          hr_req_i,
  output logic [N_CLIENTS-1:0]          hr_active_o
);
  logic [N_CLIENTS-1:0] sw_blk_q, tout_q;
  logic [N_CLIENTS-1:0] seq_blk, blk_eff, idle, tout_ev, tout_clr;

  assign blk_eff  = sw_blk_q | seq_blk;
  assign tout_clr = (reg_we_i && reg_addr_i == ADDR_TOUT) ? reg_wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_blk_q <= '0;
      tout_q   <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_CTRL) sw_blk_q <= reg_wdata_i;
      tout_q <= (tout_q & ~tout_clr) | tout_ev;
    end
  end

  assign reg_rdata_o = N_CLIENTS'(rd_sel(reg_addr_i, 32'(blk_eff), 32'(idle),
                                         32'(tout_q), 32'(hr_active_o)));

  for (genvar i = 0; i < N_CLIENTS; i++) begin : g_cl
    hrf_seq #(.DRAIN_TO(DRAIN_TO)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hr_req_i(hr_req_i[i]),
      .idle_i  (idle[i]),
      .blk_o   (seq_blk[i]),
      .hrst_o  (hr_active_o[i]),
      .tout_o  (tout_ev[i])
    );

    hrf_chan #(.DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .block_i    (blk_eff[i]),
      .flush_i    (hr_active_o[i]),
      .req_valid_i(req_valid_i[i]),
      .req_data_i (req_data_i[i*DATA_W +: DATA_W]),
      .req_ready_o(req_ready_o[i]),
      .arb_valid_o(arb_valid_o[i]),
      .arb_data_o (arb_data_o[i*DATA_W +: DATA_W]),
      .arb_ready_i(arb_ready_i[i]),
      .rsp_done_i (rsp_done_i[i]),
      .idle_o     (idle[i])
    );

    // R1: a sequencer block fences the channel
    a_r1_gate: assert property (@(posedge clk) disable iff (!rst_n)
      seq_blk[i] |-> !arb_valid_o[i] && !req_ready_o[i]);
    // R9: a timeout event always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tout_ev[i] |=> tout_q[i]);
  end
endmodule

// File: tb/hrf_top_tb.sv
`timescale 1ns/1ps
module hrf_top_tb;
  localparam int N = 8;
  localparam int DW = 16;
  localparam int MAXO = 15;
  localparam int DTO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] req_valid = '0, req_ready, arb_valid, arb_ready = '0;
  logic [N-1:0] rsp_done = '0, hr_req = '0, hr_active;
  logic [N*DW-1:0] req_data = '0, arb_data;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hrf_top #(.N_CLIENTS(N), .DATA_W(DW), .MAX_OUT(MAXO), .DRAIN_TO(DTO)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_i(req_valid),
    .req_data_i(req_data), .req_ready_o(req_ready), .arb_valid_o(arb_valid),
    .arb_data_o(arb_data), .arb_ready_i(arb_ready), .rsp_done_i(rsp_done),
    .hr_req_i(hr_req), .hr_active_o(hr_active));

  // bench model for the random phase
  logic          m_held [N];
  logic [DW-1:0] m_data [N];
  int            m_cnt  [N];
  logic [N-1:0]  m_sw;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [N-1:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = '0; arb_ready = '0; rsp_done = '0; hr_req = '0; reg_we = 1'b0;
    tick(3);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      m_held[i] = 1'b0; m_data[i] = '0; m_cnt[i] = 0;
    end
    m_sw = '0;
    tick(1);
  endtask

  function automatic logic exp_ready(int i);
    return !m_sw[i] && !m_held[i];
  endfunction
  function automatic logic exp_av(int i);
    return m_held[i] && !m_sw[i] && (m_cnt[i] < MAXO);
  endfunction
  function automatic logic [N-1:0] exp_idle();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (m_cnt[i] == 0);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    do_reset();

    // R10: reset state
    chk("R10 ready", 32'(req_ready), 32'({N{1'b1}}));
    chk("R10 arb_valid", 32'(arb_valid), 0);
    chk("R10 hr_active", 32'(hr_active), 0);
    rd(ADDR0, v); chk("R10 ctrl", 32'(v), 0);
    rd(2'd1, v);  chk("R10 idle", 32'(v), 32'({N{1'b1}}));
    rd(2'd2, v);  chk("R10 tout", 32'(v), 0);

    // random traffic with software blocking, checked every cycle (R1 R2 R3 R8)
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        chk("R1/R2 ready", 32'(req_ready[i]), 32'(exp_ready(i)));
        chk("R2/R3 arb_valid", 32'(arb_valid[i]), 32'(exp_av(i)));
        if (exp_av(i)) chk("R2 data", 32'(arb_data[i*DW +: DW]), 32'(m_data[i]));
      end
      case (reg_addr)
        2'd0: chk("R8 ctrl read", 32'(reg_rdata), 32'(m_sw));
        2'd1: chk("R8/R3 idle read", 32'(reg_rdata), 32'(exp_idle()));
        default: chk("R8 other read", 32'(reg_rdata), 0);
      endcase
      req_valid = N'($urandom);
      arb_ready = N'($urandom);
      rsp_done  = N'($urandom) & N'($urandom);
      req_data  = {$urandom, $urandom, $urandom, $urandom};
      reg_addr  = 2'($urandom) & 2'd1;
      reg_we    = ($urandom % 16) == 0;
      reg_wdata = N'($urandom) & N'($urandom);
      for (int i = 0; i < N; i++) begin
        logic rdy, av, fire, acc;
        rdy = exp_ready(i); av = exp_av(i);
        fire = av && arb_ready[i];
        acc = req_valid[i] && rdy;
        if (acc) begin m_held[i] = 1'b1; m_data[i] = req_data[i*DW +: DW]; end
        else if (fire) m_held[i] = 1'b0;
        m_cnt[i] = m_cnt[i] + (fire ? 1 : 0) - ((rsp_done[i] && m_cnt[i] > 0) ? 1 : 0);
      end
      if (reg_we && reg_addr == 2'd0) m_sw = reg_wdata;
    end
    reg_we = 1'b0;
    do_reset();

    // R3: saturation on client 0
    req_valid[0] = 1'b1; arb_ready[0] = 1'b1; req_data[0 +: DW] = 16'h1234;
    tick(40);
    req_valid[0] = 1'b0;
    chk("R3 withheld at max", 32'(arb_valid[0]), 0);
    rd(2'd1, v); chk("R3 not idle at max", 32'(v[0]), 0);
    rsp_done[0] = 1'b1; arb_ready[0] = 1'b0; tick(1); rsp_done[0] = 1'b0;
    chk("R3 released below max", 32'(arb_valid[0]), 1);
    arb_ready[0] = 1'b1; tick(1); arb_ready[0] = 1'b0;
    chk("R3 slot empty after take", 32'(req_ready[0]), 1);
    rsp_done[0] = 1'b1; tick(MAXO + 2); rsp_done[0] = 1'b0;
    rd(2'd1, v); chk("R3 drained, extra completions ignored", 32'(v[0]), 1);
    req_valid[0] = 1'b1; tick(1); req_valid[0] = 1'b0;
    arb_ready[0] = 1'b1; tick(1); arb_ready[0] = 1'b0;
    rd(2'd1, v); chk("R3 one outstanding", 32'(v[0]), 0);
    rsp_done[0] = 1'b1; tick(1); rsp_done[0] = 1'b0;
    rd(2'd1, v); chk("R3 back to idle without underflow", 32'(v[0]), 1);

    // R4 R5 R6: full hot-reset handshake on client 2
    req_valid[2] = 1'b1; arb_ready[2] = 1'b1; req_data[2*DW +: DW] = 16'hAAAA;
    tick(1); req_valid[2] = 1'b0; tick(1); arb_ready[2] = 1'b0;
    req_valid[2] = 1'b1; req_data[2*DW +: DW] = 16'hBBBB; tick(1); req_valid[2] = 1'b0;
    chk("R2 held entry offered", 32'(arb_valid[2]), 1);
    chk("R2 held data", 32'(arb_data[2*DW +: DW]), 32'h0000BBBB);
    hr_req[2] = 1'b1; tick(1);
    rd(2'd0, v); chk("R4/R8 block after request", 32'(v[2]), 1);
    chk("R1 ready gated", 32'(req_ready[2]), 0);
    chk("R1 valid gated", 32'(arb_valid[2]), 0);
    tick(3);
    chk("R4 no hot reset while busy", 32'(hr_active[2]), 0);
    rsp_done[2] = 1'b1; tick(1); rsp_done[2] = 1'b0;
    chk("R4 hot reset waits for registered idle", 32'(hr_active[2]), 0);
    tick(1);
    chk("R4 hot reset applied", 32'(hr_active[2]), 1);
    rd(2'd3, v); chk("R8 hrst read", 32'(v[2]), 1);
    tick(1);
    hr_req[2] = 1'b0; tick(1);
    chk("R6 hot reset drops first", 32'(hr_active[2]), 0);
    rd(2'd0, v); chk("R6 block still held", 32'(v[2]), 1);
    tick(1);
    rd(2'd0, v); chk("R6 block cleared", 32'(v[2]), 0);
    chk("R5 slot flushed", 32'(req_ready[2]), 1);
    chk("R5 nothing offered", 32'(arb_valid[2]), 0);
    rd(2'd1, v); chk("R5 count unchanged", 32'(v[2]), 1);

    // R7 R9: drain timeout on client 5
    req_valid[5] = 1'b1; arb_ready[5] = 1'b1;
    tick(1); req_valid[5] = 1'b0; tick(1); arb_ready[5] = 1'b0;
    hr_req[5] = 1'b1; tick(1);
    tick(DTO - 1);
    rd(2'd2, v); chk("R7 no timeout yet", 32'(v[5]), 0);
    tick(1);
    rd(2'd2, v); chk("R7 timeout flag", 32'(v[5]), 1);
    chk("R7 no hot reset", 32'(hr_active[5]), 0);
    rd(2'd0, v); chk("R7 block held", 32'(v[5]), 1);
    tick(4);
    chk("R7 still no hot reset", 32'(hr_active[5]), 0);
    hr_req[5] = 1'b0; tick(1);
    rd(2'd0, v); chk("R7 block released", 32'(v[5]), 0);
    rd(2'd2, v); chk("R7 flag sticky", 32'(v[5]), 1);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = N'(1 << 3); tick(1);
    reg_wdata = N'(1 << 5); tick(1); reg_we = 1'b0;
    rd(2'd2, v); chk("R9 write-one clears", 32'(v), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [1:0] ADDR0 = 2'd0;
endmodule